// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block is the host side of one conversion on a 12-bit, 8-channel serial ADC. The ADC runs in external-clock mode over a 4-wire SPI-style link, and the converter also returns a strobe line. A start request carries a channel number, a unipolar flag and a single-ended flag. The controller drops chip select and drives a serial clock that it derives from the system clock. It shifts an 8-bit control word out MSB first, and the power-mode field of that word is always set to the external-clock code. It keeps the clock running for a fixed frame of 24 serial clocks. During that frame it captures the 12 result bits and watches for the converter's one-clock strobe.

After the frame, chip select returns high for a programmable minimum time. The block then presents the result and a strobe-error flag together with a one-cycle done pulse. An elaboration-time guard refuses any divider setting in three cases: the serial clock period would exceed 10 µs, the frame would exceed 120 µs, or the chip-select gap is zero.

Top module: `adc_conv_ctrl`

## Requirements
- R1: The control word is sent MSB first, one bit per serial clock, on the first 8 rising edges. Its value is {1, chan[2:0], unipolar, single_ended, 1, 1}: the start bit is 1 and the power field is 1,1.
- R2: A frame has exactly 24 serial clock rising edges while cs_no is low. sclk_o is low whenever cs_no is high.
- R3: The serial clock period is 2*DIV_HALF system cycles. cs_no falls at least DIV_HALF system cycles before the first rising edge.
- R4: While cs_no stays low, din_o changes only in the cycle where sclk_o falls.
- R5: result_o holds the dout_i values sampled at rising edges 10 through 21, the first of them as bit 11. The line values at rising edges 22 to 24 do not affect the result.
- R6: strobe_err_o is 1 at done unless sstrb_i was sampled low at rising edge 8, high at rising edge 9 and low at rising edge 10. A missing strobe or a strobe two clocks long both set it.
- R7: done_o is a one-cycle pulse, and it coincides with the final result_o and strobe_err_o. busy_o is high from the cycle after the start is accepted until the done cycle inclusive.
- R8: A start_i asserted while busy_o is high is ignored. No extra frame follows, and the transmitted control word is not altered.
- R9: Between frames cs_no stays high for at least CS_HIGH_MIN system cycles, even when start_i is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, taken when idle |
| chan_i | input | 3 | Channel select |
| unipolar_i | input | 1 | 1 = unipolar coding |
| single_i | input | 1 | 1 = single-ended input |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 12 | Conversion result |
| strobe_err_o | output | 1 | Strobe pulse absent or malformed |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| din_o | output | 1 | Serial data to the converter |
| dout_i | input | 1 | Serial data from the converter |
| sstrb_i | input | 1 | Conversion strobe from the converter |

## Verification
An edge counter that is off by one shows up at the ports in three ways. The frame length at cs_no changes, the result comes out shifted by one bit, and the strobe flag trips, all in the same frame. A fault in the half-period timer changes the measured serial clock period from the very first rising edge. A fault in the start gating or the gap counter shows up as a second frame, or as a chip-select gap that is too short, within a few cycles of done.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;
  localparam int FRAME_CLKS     = 24;
  localparam int RES_BITS       = 12;
  localparam int STROBE_RISE    = 9;
  localparam int FIRST_RES_RISE = STROBE_RISE + 1;
  localparam int LAST_RES_RISE  = FIRST_RES_RISE + RES_BITS - 1;

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_GAP} conv_st_e;

  function automatic logic [7:0] ctrl_word(logic [2:0] ch, logic uni, logic sgl);
    return {1'b1, ch, uni, sgl, 2'b11};
  endfunction
endpackage

// File: rtl/adc_conv_halfper.sv
module adc_conv_halfper #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic tick_o
);
  localparam int CW = $clog2(DIV_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (hold_i)         cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = !hold_i && (cnt_q == LAST);
endmodule

// File: rtl/adc_conv_datapath.sv
module adc_conv_datapath
  import adc_conv_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [7:0]          ctrl_i,
  input  logic                shift_i,
  input  logic                sample_i,
  input  logic [IW-1:0]       rise_idx_i,
  input  logic                dout_i,
  input  logic                sstrb_i,
  output logic                din_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                strobe_err_o
);
  logic [7:0]          ctrl_q;
  logic [RES_BITS-1:0] res_q;
  logic                err_q;
  logic                in_res, in_strb;

  assign in_res  = rise_idx_i >= IW'(FIRST_RES_RISE) && rise_idx_i <= IW'(LAST_RES_RISE);
  assign in_strb = rise_idx_i >= IW'(STROBE_RISE - 1) && rise_idx_i <= IW'(STROBE_RISE + 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      res_q  <= '0;
      err_q  <= 1'b0;
    end else if (load_i) begin
      ctrl_q <= ctrl_i;
      res_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (shift_i) ctrl_q <= {ctrl_q[6:0], 1'b0};
      if (sample_i) begin
        if (in_res) res_q <= {res_q[RES_BITS-2:0], dout_i};
        if (in_strb && (sstrb_i != (rise_idx_i == IW'(STROBE_RISE)))) err_q <= 1'b1;
      end
    end
  end

  assign din_o        = ctrl_q[7];
  assign result_o     = res_q;
  assign strobe_err_o = err_q;

  // R1
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> din_o);

  // R5
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_i && !load_i) |=> $stable(result_o));
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_conv_pkg::*;
#(
  parameter int DIV_HALF      = 4,
  parameter int CS_HIGH_MIN   = 3,
  parameter int CLK_PERIOD_NS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [2:0]          chan_i,
  input  logic                unipolar_i,
  input  logic                single_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                strobe_err_o,
  output logic                cs_no,
  output logic                sclk_o,
  output logic                din_o,
  input  logic                dout_i,
  input  logic                sstrb_i
);
  localparam int EW = $clog2(FRAME_CLKS + 1);
  localparam int GW = $clog2(CS_HIGH_MIN + 1);
  localparam longint SCLK_NS  = 2 * longint'(DIV_HALF) * CLK_PERIOD_NS;
  localparam longint FRAME_NS = (2 * FRAME_CLKS + 1) * longint'(DIV_HALF) * CLK_PERIOD_NS;
  localparam bit CFG_BAD = DIV_HALF < 2 || CS_HIGH_MIN < 1 || SCLK_NS > 10000 || FRAME_NS > 120000;

  if (CFG_BAD) begin : g_cfg_bad
    initial $fatal(1, "adc_conv_ctrl: divider or gap setting violates timing limits");
  end

  conv_st_e      st_q;
  logic [EW-1:0] edges_q, rise_idx;
  logic [GW-1:0] gap_q;
  logic          tick, hold, accept, rise_ev, fall_ev, last_edge, gap_done;

  assign hold      = (st_q == ST_IDLE) || (st_q == ST_GAP);
  assign accept    = (st_q == ST_IDLE) && start_i;
  assign last_edge = edges_q == EW'(FRAME_CLKS);
  assign rise_ev   = tick && ((st_q == ST_SETUP) || (st_q == ST_LOW && !last_edge));
  assign fall_ev   = tick && (st_q == ST_HIGH);
  assign gap_done  = (st_q == ST_GAP) && (gap_q == GW'(CS_HIGH_MIN - 1));
  assign rise_idx  = edges_q + EW'(1);

  adc_conv_halfper #(.DIV_HALF(DIV_HALF)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .tick_o (tick)
  );

  adc_conv_datapath #(.IW(EW)) u_dp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (accept),
    .ctrl_i       (ctrl_word(chan_i, unipolar_i, single_i)),
    .shift_i      (fall_ev),
    .sample_i     (rise_ev),
    .rise_idx_i   (rise_idx),
    .dout_i       (dout_i),
    .sstrb_i      (sstrb_i),
    .din_o        (din_o),
    .result_o     (result_o),
    .strobe_err_o (strobe_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      edges_q <= '0;
      gap_q   <= '0;
    end else begin
      if (rise_ev) edges_q <= rise_idx;
      unique case (st_q)
        ST_IDLE:  if (accept) begin st_q <= ST_SETUP; edges_q <= '0; end
        ST_SETUP: if (tick) st_q <= ST_HIGH;
        ST_HIGH:  if (tick) st_q <= ST_LOW;
        ST_LOW:   if (tick) begin
                    if (last_edge) begin st_q <= ST_GAP; gap_q <= '0; end
                    else           st_q <= ST_HIGH;
                  end
        ST_GAP:   begin
                    gap_q <= gap_q + GW'(1);
                    if (gap_done) st_q <= ST_IDLE;
                  end
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = st_q != ST_IDLE;
  assign done_o = gap_done;
  assign cs_no  = !(st_q == ST_SETUP || st_q == ST_HIGH || st_q == ST_LOW);
  assign sclk_o = st_q == ST_HIGH;

  // R2
  cs_sclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  // R3
  sclk_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_o) |-> $past(tick));

  // R4
  din_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no) && !$stable(din_o)) |-> $fell(sclk_o));

  // R7
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));

  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb_top;
  localparam int DIV_HALF    = 4;
  localparam int CS_HIGH_MIN = 3;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, unipolar_i = 1'b0, single_i = 1'b0;
  logic [2:0]  chan_i = '0;
  logic        busy_o, done_o, strobe_err_o, cs_no, sclk_o, din_o;
  logic [11:0] result_o;
  logic        dout_i = 1'b0, sstrb_i = 1'b0;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  adc_conv_ctrl #(.DIV_HALF(DIV_HALF), .CS_HIGH_MIN(CS_HIGH_MIN), .CLK_PERIOD_NS(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .chan_i(chan_i),
    .unipolar_i(unipolar_i), .single_i(single_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .strobe_err_o(strobe_err_o), .cs_no(cs_no), .sclk_o(sclk_o),
    .din_o(din_o), .dout_i(dout_i), .sstrb_i(sstrb_i)
  );

  // converter model
  int          cyc = 0, nrise = 0, nfall = 0, frames = 0;
  int          last_rise = 0, per_min = 0, per_max = 0, setup_len = 0;
  int          cs_fall_cyc = 0, cs_rise_cyc = 0, gap_len = 0;
  int          strobe_mode = 0;
  logic [11:0] model_val = '0;
  logic [7:0]  cap = '0;

  always @(posedge clk) cyc++;

  always @(negedge cs_no) begin
    nrise = 0; nfall = 0; frames++;
    per_min = 1000000; per_max = 0;
    cs_fall_cyc = cyc;
    gap_len = cyc - cs_rise_cyc;
  end

  always @(posedge cs_no) begin
    cs_rise_cyc = cyc;
    sstrb_i <= 1'b0;
    dout_i  <= 1'b0;
  end

  always @(posedge sclk_o) if (!cs_no) begin
    nrise++;
    if (nrise <= 8) cap = {cap[6:0], din_o};
    if (nrise == 1) setup_len = cyc - cs_fall_cyc;
    else begin
      if (cyc - last_rise < per_min) per_min = cyc - last_rise;
      if (cyc - last_rise > per_max) per_max = cyc - last_rise;
    end
    last_rise = cyc;
  end

  always @(negedge sclk_o) if (!cs_no) begin
    nfall++;
    sstrb_i <= (strobe_mode == 1) ? 1'b0 : ((nfall == 8) || (strobe_mode == 2 && nfall == 9));
    dout_i  <= (nfall >= 9 && nfall <= 20) ? model_val[20 - nfall] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 3000) begin @(negedge clk); n++; end
  endtask

  // {chan, unipolar, single, strobe_mode[1:0], value[11:0]}
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 1'b1, 1'b1, 2'd0, 12'h000},
    {3'd7, 1'b0, 1'b0, 2'd0, 12'hFFF},
    {3'd5, 1'b1, 1'b0, 2'd0, 12'hA5C},
    {3'd2, 1'b0, 1'b1, 2'd0, 12'h801},
    {3'd3, 1'b1, 1'b1, 2'd1, 12'h3C7},
    {3'd6, 1'b0, 1'b1, 2'd2, 12'h5A5}
  };

  task automatic run_vec(input logic [18:0] v);
    logic [7:0] exp_ctrl;
    exp_ctrl    = {1'b1, v[18:16], v[15], v[14], 2'b11};
    strobe_mode = int'(v[13:12]);
    model_val   = v[11:0];
    @(negedge clk);
    chan_i = v[18:16]; unipolar_i = v[15]; single_i = v[14]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R7 busy after start", int'(busy_o), 1);
    wait_done();
    chk(done_o == 1'b1, "R7 done seen", int'(done_o), 1);
    chk(cap == exp_ctrl, "R1 control word", int'(cap), int'(exp_ctrl));
    chk(nrise == 24, "R2 rising edges", nrise, 24);
    chk(per_min == 2*DIV_HALF && per_max == 2*DIV_HALF, "R3 sclk period", per_max, 2*DIV_HALF);
    chk(setup_len >= DIV_HALF, "R3 cs setup", setup_len, DIV_HALF);
    chk(result_o == v[11:0], "R5 result", int'(result_o), int'(v[11:0]));
    chk(strobe_err_o == (v[13:12] != 2'd0), "R6 strobe flag", int'(strobe_err_o), int'(v[13:12] != 2'd0));
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R7 done single cycle", int'({done_o, busy_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_no == 1'b1 && sclk_o == 1'b0, "R2 reset cs/sclk", int'({cs_no, sclk_o}), 2);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R7 reset busy/done", int'({busy_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R8: start during a frame is ignored
    begin
      int f0;
      strobe_mode = 0; model_val = 12'h123;
      @(negedge clk);
      chan_i = 3'd1; unipolar_i = 1'b0; single_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (40) @(negedge clk);
      chan_i = 3'd6; unipolar_i = 1'b1; single_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      f0 = frames;
      wait_done();
      repeat (30) @(negedge clk);
      chk(frames == f0, "R8 no extra frame", frames, f0);
      chk(cap == 8'b1_001_0_0_11, "R8 control word kept", int'(cap), int'(8'b10010011));
      chk(result_o == 12'h123, "R8 result kept", int'(result_o), 'h123);
    end

    // R9: start held high, back-to-back frames
    begin
      int f0;
      strobe_mode = 0; model_val = 12'h456;
      f0 = frames;
      @(negedge clk);
      chan_i = 3'd4; start_i = 1'b1;
      wait_done();
      @(negedge clk);
      wait_done();
      start_i = 1'b0;
      @(negedge clk);
      chk(frames == f0 + 2, "R9 two frames", frames, f0 + 2);
      chk(gap_len >= CS_HIGH_MIN, "R9 cs high gap", gap_len, CS_HIGH_MIN);
      wait_done();
      repeat (5) @(negedge clk);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule